// File: doc/BRIEF.md
# Intel HEX Record Loader

This block takes Intel HEX text as a stream of ASCII characters and turns it into byte writes on a 32-bit memory port that has per-lane byte enables. It accepts one character per clock while `in_valid` is high. It decodes each record and checks its checksum. It keeps a base address that is set by segment and linear-base records. For every data byte it produces one write cycle, placing the byte in the lane chosen by the low two bits of its byte address.

The loader sits between a character source (a UART receiver or a boot FIFO, for example) and a RAM write port. Data bytes are written as soon as they have been decoded. The checksum result therefore only affects the error reporting and whether the record's control effect is applied. `error` is a sticky flag. `bad_cnt` is a saturating count of records whose checksum failed. `done` rises when a valid end-of-file record arrives, and from then on all input is ignored until reset.

Top module: `hex_loader`

## Requirements
- R1: While `rst_n` is low, and right after it goes high, `mem_we`, `mem_be`, `mem_wdata`, `done`, `error` and `bad_cnt` are all zero, and the base address is zero.
- R2: A type 0x00 record produces one write cycle per data byte, in arrival order. The cycle comes one clock after the edge that accepts the byte's second hex digit. Byte address = base + record address + byte index. `mem_addr` = byte address >> 2. `mem_be` has only bit (byte address mod 4) set. The byte sits in that lane of `mem_wdata`, and all other lanes are zero.
- R3: A record is ':' followed by pairs of hex digits: byte count, address high byte, address low byte, type, data bytes, checksum. Digits A–F are accepted in either case. CR (0x0D) and LF (0x0A) between records are ignored.
- R4: A type 0x02 record with a valid checksum loads the base with its two payload bytes (first byte most significant) shifted left by 4.
- R5: A type 0x04 record with a valid checksum loads the base with its two payload bytes (first byte most significant) shifted left by 16.
- R6: A record whose bytes, including the checksum, do not add up to 0 modulo 256 sets `error` and increments `bad_cnt`. The count saturates at its maximum value. The record's base or end-of-file effect is not applied, but its data writes have already been made.
- R7: A character that is not a hex digit inside a record, or a character other than ':', CR or LF between records, sets `error` without changing `bad_cnt`, and the record is dropped. If that character is ':', a new record starts with it.
- R8: A type 0x01 record with a valid checksum raises `done`. After that, no input causes writes or changes `error` or `bad_cnt` until reset.
- R9: A record of any other type (for example 0x03 or 0x05), or a type 0x00 record with byte count 0, makes no write and leaves the base unchanged.
- R10: `in_ready` is high at all times, so one character is consumed on every clock where `in_valid` is high.
- R11: Once set, `error` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A character is present on `in_data` |
| in_data | input | 8 | ASCII character |
| in_ready | output | 1 | Character accepted (always high) |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | 32-bit word address |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Write data, with the byte in its lane |
| done | output | 1 | Valid end-of-file record seen |
| error | output | 1 | Sticky error flag |
| bad_cnt | output | CNT_W | Saturating count of checksum failures |

## Verification
The assertions check properties that must hold on every cycle. Each write has exactly one byte enable and zeros outside the enabled lane. `error` and `done` never fall. The failure count only ever steps by one, and only while `error` is high. Once `done` is high, the memory port stays quiet and the flags stay frozen. Only the bench's record scenarios can show that the address arithmetic is right: segment and linear base handling, carries across word boundaries, lane placement in little-endian order, recovery after a stray ':', and where the count saturates.

// File: rtl/hexld_pkg.sv
package hexld_pkg;
   typedef enum logic [1:0] {PS_IDLE, PS_HI, PS_LO, PS_END} pstate_t;

   localparam logic [7:0] CH_COLON = 8'h3A;
   localparam logic [7:0] CH_CR    = 8'h0D;
   localparam logic [7:0] CH_LF    = 8'h0A;

   localparam logic [7:0] REC_DATA = 8'h00;
   localparam logic [7:0] REC_EOF  = 8'h01;
   localparam logic [7:0] REC_SEG  = 8'h02;
   localparam logic [7:0] REC_LIN  = 8'h04;

   localparam int LANES   = 4;
   localparam int LANE_W  = 8;
   localparam int BYTE_AW = 32;
endpackage

// File: rtl/hexld_nibble.sv
module hexld_nibble (
   input  logic [7:0] ch,
   output logic [3:0] val,
   output logic       ok
);
   always_comb begin
      val = 4'h0;
      ok  = 1'b0;
      if (ch >= 8'h30 && ch <= 8'h39) begin
         val = ch[3:0];
         ok  = 1'b1;
      end else if ((ch >= 8'h41 && ch <= 8'h46) || (ch >= 8'h61 && ch <= 8'h66)) begin
         val = ch[3:0] + 4'd9;
         ok  = 1'b1;
      end
   end
endmodule

// File: rtl/hexld_parser.sv
module hexld_parser
   import hexld_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        ch_valid,
   input  logic [7:0]  ch,
   output logic        wr_stb,
   output logic [7:0]  wr_byte,
   output logic [15:0] rec_addr,
   output logic [7:0]  rec_off,
   output logic        set_seg,
   output logic        set_lin,
   output logic [15:0] base_val,
   output logic        ck_fail,
   output logic        err_o,
   output logic        done_o
);
   pstate_t     st;
   logic [3:0]  hi_nib, nib;
   logic        is_hex;
   logic [8:0]  idx, rel;
   logic [7:0]  len, rtype, sum, sum_n, cur;
   logic [15:0] addr_q, pay;
   logic        err_q;
   logic        take, is_data, is_ck, ck_ok;

   hexld_nibble u_nib (.ch(ch), .val(nib), .ok(is_hex));

   assign cur     = {hi_nib, nib};
   assign sum_n   = sum + cur;
   assign rel     = idx - 9'd4;
   assign is_data = (idx >= 9'd4) && (rel < {1'b0, len});
   assign is_ck   = (idx >= 9'd4) && (rel == {1'b0, len});
   assign take    = ch_valid && (st == PS_LO) && is_hex;

   assign wr_stb   = take && is_data && (rtype == REC_DATA);
   assign wr_byte  = cur;
   assign rec_off  = rel[7:0];
   assign rec_addr = addr_q;
   assign ck_ok    = take && is_ck && (sum_n == 8'h00);
   assign ck_fail  = take && is_ck && (sum_n != 8'h00);
   assign set_seg  = ck_ok && (rtype == REC_SEG);
   assign set_lin  = ck_ok && (rtype == REC_LIN);
   assign base_val = pay;
   assign err_o    = err_q;
   assign done_o   = (st == PS_END);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= PS_IDLE;
         hi_nib <= 4'h0;
         idx    <= 9'd0;
         len    <= 8'h00;
         addr_q <= 16'h0000;
         rtype  <= 8'h00;
         sum    <= 8'h00;
         pay    <= 16'h0000;
         err_q  <= 1'b0;
      end else if (ch_valid) begin
         case (st)
            PS_IDLE: begin
               if (ch == CH_COLON) begin
                  st  <= PS_HI;
                  idx <= 9'd0;
                  sum <= 8'h00;
               end else if (ch != CH_CR && ch != CH_LF) begin
                  err_q <= 1'b1;
               end
            end
            PS_HI, PS_LO: begin
               if (!is_hex) begin
                  err_q <= 1'b1;
                  if (ch == CH_COLON) begin
                     st  <= PS_HI;
                     idx <= 9'd0;
                     sum <= 8'h00;
                  end else begin
                     st <= PS_IDLE;
                  end
               end else if (st == PS_HI) begin
                  hi_nib <= nib;
                  st     <= PS_LO;
               end else begin
                  sum <= sum_n;
                  idx <= idx + 9'd1;
                  st  <= PS_HI;
                  case (idx)
                     9'd0:    len          <= cur;
                     9'd1:    addr_q[15:8] <= cur;
                     9'd2:    addr_q[7:0]  <= cur;
                     9'd3:    rtype        <= cur;
                     default: if (is_data) pay <= {pay[7:0], cur};
                  endcase
                  if (is_ck) begin
                     if (sum_n != 8'h00) begin
                        err_q <= 1'b1;
                        st    <= PS_IDLE;
                     end else if (rtype == REC_EOF) begin
                        st <= PS_END;
                     end else begin
                        st <= PS_IDLE;
                     end
                  end
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/hexld_addr.sv
module hexld_addr
   import hexld_pkg::*;
#(
   parameter int ADDR_W = 30
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_seg,
   input  logic              set_lin,
   input  logic [15:0]       val,
   input  logic [15:0]       rec_addr,
   input  logic [7:0]        rec_off,
   output logic [ADDR_W-1:0] word_addr,
   output logic [1:0]        lane
);
   localparam int LANE_BITS = $clog2(LANES);

   logic [BYTE_AW-1:0] base, byte_addr;

   always_ff @(posedge clk) begin
      if (!rst_n)       base <= '0;
      else if (set_seg) base <= {12'h000, val, 4'h0};
      else if (set_lin) base <= {val, 16'h0000};
   end

   assign byte_addr = base + {16'h0000, rec_addr} + {24'h000000, rec_off};
   assign word_addr = byte_addr[ADDR_W+LANE_BITS-1:LANE_BITS];
   assign lane      = byte_addr[LANE_BITS-1:0];
endmodule

// File: rtl/hex_loader.sv
module hex_loader
   import hexld_pkg::*;
#(
   parameter int ADDR_W  = 30,
   parameter int CNT_W   = 8,
   parameter bit CNT_SAT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [7:0]        in_data,
   output logic              in_ready,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [3:0]        mem_be,
   output logic [31:0]       mem_wdata,
   output logic              done,
   output logic              error,
   output logic [CNT_W-1:0]  bad_cnt
);
   if (ADDR_W < 14 || ADDR_W > 30) begin : g_bad_aw
      $error("hex_loader: ADDR_W must lie in 14..30");
   end
   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cw
      $error("hex_loader: CNT_W must lie in 1..32");
   end

   logic              wr_stb, set_seg, set_lin, ck_fail;
   logic [7:0]        wr_byte, rec_off;
   logic [15:0]       rec_addr, base_val;
   logic [ADDR_W-1:0] w_addr;
   logic [1:0]        lane;

   assign in_ready = 1'b1;

   hexld_parser u_parse (
      .clk(clk), .rst_n(rst_n), .ch_valid(in_valid), .ch(in_data),
      .wr_stb(wr_stb), .wr_byte(wr_byte), .rec_addr(rec_addr), .rec_off(rec_off),
      .set_seg(set_seg), .set_lin(set_lin), .base_val(base_val),
      .ck_fail(ck_fail), .err_o(error), .done_o(done)
   );

   hexld_addr #(.ADDR_W(ADDR_W)) u_addr (
      .clk(clk), .rst_n(rst_n), .set_seg(set_seg), .set_lin(set_lin),
      .val(base_val), .rec_addr(rec_addr), .rec_off(rec_off),
      .word_addr(w_addr), .lane(lane)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem_we   <= 1'b0;
         mem_addr <= '0;
      end else begin
         mem_we <= wr_stb;
         if (wr_stb) mem_addr <= w_addr;
      end
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      always_ff @(posedge clk) begin
         if (!rst_n || !wr_stb) begin
            mem_be[i]                      <= 1'b0;
            mem_wdata[i*LANE_W +: LANE_W] <= '0;
         end else begin
            mem_be[i]                      <= (lane == i);
            mem_wdata[i*LANE_W +: LANE_W] <= (lane == i) ? wr_byte : '0;
         end
      end
   end

   if (CNT_SAT) begin : g_sat
      always_ff @(posedge clk) begin
         if (!rst_n)                         bad_cnt <= '0;
         else if (ck_fail && bad_cnt != '1)  bad_cnt <= bad_cnt + 1'b1;
      end
   end else begin : g_wrap
      always_ff @(posedge clk) begin
         if (!rst_n)       bad_cnt <= '0;
         else if (ck_fail) bad_cnt <= bad_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/hexld_chk.sv
module hexld_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_ready,
   input logic             mem_we,
   input logic [3:0]       mem_be,
   input logic [31:0]      mem_wdata,
   input logic             done,
   input logic             error,
   input logic [CNT_W-1:0] bad_cnt
);
   logic [31:0] lane_mask;
   always_comb begin
      for (int i = 0; i < 4; i++) lane_mask[i*8 +: 8] = {8{mem_be[i]}};
   end

   // R10
   ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n) in_ready);
   // R2
   one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> $countones(mem_be) == 1);
   // R2
   lane_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_wdata & ~lane_mask) == 32'h0);
   // R2
   quiet_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we |-> mem_be == 4'h0);
   // R11
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      error |=> error);
   // R8
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done && !mem_we);
   // R8
   done_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> $stable(error) && $stable(bad_cnt));
   // R6
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(bad_cnt) |-> (bad_cnt == $past(bad_cnt) + 1'b1) && error);
endmodule

bind hex_loader hexld_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .mem_we(mem_we),
   .mem_be(mem_be), .mem_wdata(mem_wdata), .done(done), .error(error),
   .bad_cnt(bad_cnt)
);

// File: tb/tb_hex_loader.sv
`timescale 1ns/1ps
module tb_hex_loader;
   localparam int AW = 30;
   localparam int CW = 8;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          in_valid;
   logic [7:0]    in_data;
   logic          in_ready, mem_we, done, error;
   logic [AW-1:0] mem_addr;
   logic [3:0]    mem_be;
   logic [31:0]   mem_wdata;
   logic [CW-1:0] bad_cnt;

   always #2 clk = ~clk;

   hex_loader #(.ADDR_W(AW), .CNT_W(CW)) dut (.*);

   int total = 0, bad = 0, cyc = 0, wn = 0;
   bit fin = 1'b0;
   logic [AW-1:0] log_a [16];
   logic [3:0]    log_b [16];
   logic [31:0]   log_d [16];

   always @(negedge clk) begin
      if (rst_n === 1'b1 && mem_we === 1'b1 && wn < 16) begin
         log_a[wn] = mem_addr;
         log_b[wn] = mem_be;
         log_d[wn] = mem_wdata;
         wn = wn + 1;
      end
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000 && !fin) begin
         bad = bad + 1;
         total = total + 1;
         $display("FAIL R10 watchdog act=%0d exp=<150000", cyc);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      total = total + 1;
      if (!ok) begin
         bad = bad + 1;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   task automatic put(input logic [7:0] c);
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = c;
      forever begin
         @(posedge clk);
         if (in_ready) break;
      end
      #1 in_valid = 1'b0;
   endtask

   function automatic logic [7:0] hexch(input logic [3:0] v, input bit lc);
      if (v < 10) return 8'h30 + {4'h0, v};
      return (lc ? 8'h57 : 8'h37) + {4'h0, v};
   endfunction

   task automatic put_byte(input logic [7:0] b, input bit lc);
      put(hexch(b[7:4], lc));
      put(hexch(b[3:0], lc));
   endtask

   task automatic send_rec(input logic [7:0] t, input logic [15:0] a, input int n,
                           input logic [31:0] d, input bit corrupt, input bit lc);
      logic [7:0] s;
      s = n[7:0] + a[15:8] + a[7:0] + t;
      for (int i = 0; i < n; i++) s = s + d[8*i +: 8];
      s = 8'h00 - s;
      if (corrupt) s = s ^ 8'h01;
      put(8'h3A);
      put_byte(n[7:0], lc);
      put_byte(a[15:8], lc);
      put_byte(a[7:0], lc);
      put_byte(t, lc);
      for (int i = 0; i < n; i++) put_byte(d[8*i +: 8], lc);
      put_byte(s, lc);
      put(8'h0D);
      put(8'h0A);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(mem_we == 0 && mem_be == 0 && mem_wdata == 0, "R1", "port in reset",
          {31'h0, mem_we, mem_be, mem_wdata}, 64'h0);
      chk(done == 0 && error == 0 && bad_cnt == 0, "R1", "flags in reset",
          {done, error, bad_cnt}, 64'h0);
      rst_n = 1'b1;
   endtask

   typedef struct packed {
      logic [7:0]  t;
      logic [15:0] a;
      logic [7:0]  n;
      logic [31:0] d;
      logic        corrupt;
      logic        lc;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t TBL [NV] = '{
      '{8'h00, 16'h0000, 8'd4, 32'h03020100, 1'b0, 1'b0}, // R2 little-endian word
      '{8'h00, 16'h0006, 8'd3, 32'h00CCBBAA, 1'b0, 1'b1}, // R2 R3 word carry, lower case
      '{8'h02, 16'h0000, 8'd2, 32'h00003412, 1'b0, 1'b0}, // R4 segment 0x1234
      '{8'h00, 16'h0011, 8'd2, 32'h00006655, 1'b0, 1'b0}, // R4 offset applied
      '{8'h00, 16'h0020, 8'd1, 32'h00000077, 1'b1, 1'b0}, // R6 bad checksum, still written
      '{8'h04, 16'h0000, 8'd2, 32'h00000200, 1'b0, 1'b1}, // R5 linear 0x0002
      '{8'h00, 16'hFFFF, 8'd1, 32'h00000099, 1'b0, 1'b0}, // R5 top of window
      '{8'h03, 16'h0000, 8'd4, 32'hDEADBEEF, 1'b0, 1'b0}, // R9 unknown type
      '{8'h00, 16'h0040, 8'd0, 32'h00000000, 1'b0, 1'b0}  // R9 empty data record
   };

   initial begin
      logic [31:0] base, ba;
      logic        exp_err;
      int          exp_cnt;
      int          nexp;
      bit          okw;
      rst_n = 1'b0; in_valid = 1'b0; in_data = 8'h00;
      do_reset();
      idle(1);
      chk(in_ready == 1'b1, "R10", "ready after reset", {63'h0, in_ready}, 64'h1);

      // R3: line endings alone are harmless
      put(8'h0D); put(8'h0A); put(8'h0D); put(8'h0A);
      idle(2);
      chk(error == 0, "R3", "CR/LF ignored", {63'h0, error}, 64'h0);

      base = 32'h0; exp_err = 1'b0; exp_cnt = 0;
      for (int k = 0; k < NV; k++) begin
         wn = 0;
         send_rec(TBL[k].t, TBL[k].a, int'(TBL[k].n), TBL[k].d, TBL[k].corrupt, TBL[k].lc);
         idle(2);
         nexp = (TBL[k].t == 8'h00) ? int'(TBL[k].n) : 0;
         chk(wn == nexp, "R2/R9", $sformatf("write count entry %0d", k), wn, nexp);
         okw = 1'b1;
         for (int i = 0; i < nexp && i < wn; i++) begin
            ba = base + {16'h0, TBL[k].a} + i;
            if (log_a[i] != ba[31:2] || log_b[i] != (4'h1 << ba[1:0]) ||
                log_d[i] != ({24'h0, TBL[k].d[8*i +: 8]} << (8*ba[1:0]))) begin
               okw = 1'b0;
               $display("FAIL R2/R4/R5 entry %0d byte %0d act=%0h/%0h/%0h exp=%0h/%0h/%0h",
                        k, i, log_a[i], log_b[i], log_d[i], ba[31:2], 4'h1 << ba[1:0],
                        {24'h0, TBL[k].d[8*i +: 8]} << (8*ba[1:0]));
            end
         end
         total = total + 1;
         if (!okw) bad = bad + 1;
         if (TBL[k].corrupt) begin
            exp_err = 1'b1;
            exp_cnt = exp_cnt + 1;
         end else if (TBL[k].t == 8'h02) begin
            base = {12'h0, TBL[k].d[7:0], TBL[k].d[15:8], 4'h0};
         end else if (TBL[k].t == 8'h04) begin
            base = {TBL[k].d[7:0], TBL[k].d[15:8], 16'h0};
         end
         chk(error == exp_err, "R6/R11", $sformatf("error entry %0d", k), {63'h0, error}, {63'h0, exp_err});
         chk(bad_cnt == exp_cnt[CW-1:0], "R6", $sformatf("bad_cnt entry %0d", k), bad_cnt, exp_cnt);
      end

      // R7: stray character mid-record, then a ':' restart
      do_reset();
      put(8'h3A); put(8'h30); put(8'h32); put(8'h58);
      idle(2);
      chk(error == 1, "R7", "non-hex sets error", {63'h0, error}, 64'h1);
      chk(bad_cnt == 0, "R7", "non-hex not counted", bad_cnt, 64'h0);
      wn = 0;
      put(8'h3A); put(8'h30); put(8'h34);
      send_rec(8'h00, 16'h0101, 1, 32'h0000005A, 1'b0, 1'b0);
      idle(2);
      chk(wn == 1 && log_a[0] == 30'h40 && log_b[0] == 4'h2 && log_d[0] == 32'h00005A00,
          "R7", "restart on colon", {log_a[0], log_b[0], log_d[0]}, {30'h40, 4'h2, 32'h5A00});
      chk(bad_cnt == 0, "R7", "restart not counted", bad_cnt, 64'h0);

      // R6: saturation of the failure count
      do_reset();
      for (int i = 0; i < 260; i++) send_rec(8'h00, 16'h0000, 0, 32'h0, 1'b1, 1'b0);
      idle(2);
      chk(bad_cnt == 8'hFF, "R6", "count saturates", bad_cnt, 64'hFF);
      chk(error == 1, "R11", "error held", {63'h0, error}, 64'h1);

      // R8: end of file needs a valid checksum, then input is ignored
      do_reset();
      send_rec(8'h01, 16'h0000, 0, 32'h0, 1'b1, 1'b0);
      idle(2);
      chk(done == 0, "R8", "bad EOF not done", {63'h0, done}, 64'h0);
      send_rec(8'h01, 16'h0000, 0, 32'h0, 1'b0, 1'b0);
      idle(2);
      chk(done == 1, "R8", "EOF sets done", {63'h0, done}, 64'h1);
      wn = 0;
      send_rec(8'h00, 16'h0000, 4, 32'h11223344, 1'b1, 1'b0);
      put(8'h51);
      idle(3);
      chk(wn == 0, "R8", "no writes after done", wn, 64'h0);
      chk(bad_cnt == 1 && error == 1 && done == 1, "R8", "flags frozen after done",
          {error, done, bad_cnt}, {1'b1, 1'b1, 8'h01});

      fin = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule